// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps 32-bit effective addresses to physical addresses through two small banks of programmable block entries, one bank for instruction fetches and one for data accesses. Each entry is a pair of 32-bit registers. The upper word holds the block's effective base, a block-length mask and two privilege enables. The lower word holds the physical base of the block. A request names the side, the privilege level and whether relocation is on for that side. One clock edge later the unit returns the physical address and a hit flag.

Software reaches the entries through a special-register port. The port takes a 10-bit register number, writes on a strobe and reads back combinationally. Each write to an entry raises a one-cycle flush pulse. A downstream translation cache uses this pulse to drop mappings that may now be stale. The unit does not walk page tables, handle cache attributes or raise protection faults. A miss is only reported, so the caller can fall back to another mechanism.

Top module: `blk_xlate`

## Requirements
- R1: With `xlate_en` low, a request returns `rsp_pa` equal to `req_ea` with `rsp_hit` high, and no bank is searched.
- R2: Upper-word bit 1 enables an entry for supervisor requests (`req_user`=0). Upper-word bit 0 enables it for user requests (`req_user`=1). An entry whose enable for the current privilege is clear never matches.
- R3: The block-length field sits in upper bits [12:2]. The compare mask is the 32-bit inverse of that field, shifted left by 17. An entry matches when upper bits [31:17] (lower bits taken as zero) equal `req_ea` ANDed with the mask.
- R4: On a hit, `rsp_pa` = (lower word with bits [16:0] cleared) + (`req_ea` − (upper word with bits [16:0] cleared)), modulo 2^32.
- R5: Entries are searched from index 0 upward and the lowest matching index wins. When no entry matches, `rsp_hit` is 0 and `rsp_pa` is 0.
- R6: The instruction bank (`req_side`=0) and the data bank (`req_side`=1) are independent. An entry in one bank never affects a lookup on the other side.
- R7: A register number is mapped when bits [9:5] are 0x10 or 0x11. Bit 3 selects the data bank (1) or the instruction bank (0). The entry index is bits [2:1], plus 4 when bit 5 is set. Bit 0 selects the lower word (1) or the upper word (0). Bit 4 is ignored.
- R8: A read of a mapped number returns the full 32-bit word last written. A read of an unmapped number returns 0. A write to an unmapped number changes no entry.
- R9: A write to a mapped number drives `cache_flush` high for exactly the following cycle. A write to an unmapped number raises no flush.
- R10: Reset clears every word. After reset, every read returns 0 and every relocated lookup misses.
- R11: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. A lookup uses the entry contents as they stood before any write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_side | input | 1 | 0 instruction bank, 1 data bank |
| req_user | input | 1 | 1 user privilege, 0 supervisor |
| xlate_en | input | 1 | Relocation enable for the requesting side |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_pa | output | 32 | Physical address |
| rsp_hit | output | 1 | Translation found (or pass-through) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Special-register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| cache_flush | output | 1 | One-cycle flush request to downstream translation caches |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 8 entries per bank, an 11-bit length field and a 17-bit block shift. Blocks therefore range from 128 KB to 256 MB. This lets random entries with contiguous masks of every legal length overlap one another. Random addresses are aimed inside programmed blocks, so priority between overlapping entries and both privilege enables are reached often. Directed cases cover the decode aliases of bit 4 and bit 5, unmapped numbers, side isolation and the pass-through path.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

   localparam int IDX_W = 3;

   typedef enum logic {
      SIDE_INSN = 1'b0,
      SIDE_DATA = 1'b1
   } side_e;

   typedef struct packed {
      logic             mapped;
      side_e            side;
      logic             lower;
      logic [IDX_W-1:0] idx;
   } regsel_t;

endpackage

// File: rtl/blk_xlate_regsel.sv
module blk_xlate_regsel
   import blk_xlate_pkg::*;
#(
   parameter int SPR_W = 10
) (
   input  logic [SPR_W-1:0] addr,
   output regsel_t          sel
);
   localparam logic [SPR_W-6:0] GRP_A = (SPR_W-5)'(5'h10);
   localparam logic [SPR_W-6:0] GRP_B = (SPR_W-5)'(5'h11);

   logic unused_bit4;
   assign unused_bit4 = addr[4];

   always_comb begin
      sel.mapped = (addr[SPR_W-1:5] == GRP_A) || (addr[SPR_W-1:5] == GRP_B);
      sel.side   = addr[3] ? SIDE_DATA : SIDE_INSN;
      sel.lower  = addr[0];
      sel.idx    = {addr[5], addr[2:1]};
   end
endmodule

// File: rtl/blk_xlate_bank.sv
module blk_xlate_bank
   import blk_xlate_pkg::*;
#(
   parameter int N_ENT = 8,
   parameter int W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic             wlower,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     up_q [N_ENT],
   output logic [W-1:0]     lo_q [N_ENT]
);
   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_q[e] <= '0;
            lo_q[e] <= '0;
         end else if (we && (widx == IDX_W'(e))) begin
            if (wlower) lo_q[e] <= wdata;
            else        up_q[e] <= wdata;
         end
      end
   end
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry #(
   parameter int W       = 32,
   parameter int LEN_W   = 11,
   parameter int LEN_LSB = 2,
   parameter int SHIFT   = 17
) (
   input  logic [W-1:0] up,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] ea,
   input  logic         user,
   output logic         hit,
   output logic [W-1:0] pa
);
   localparam logic [W-1:0] BASE_MASK = {W{1'b1}} << SHIFT;

   logic [W-1:0] cmp_mask;
   logic [W-1:0] eff_base;
   logic [W-1:0] real_base;
   logic         priv_ok;

   always_comb begin
      cmp_mask  = (~W'(up[LEN_LSB +: LEN_W])) << SHIFT;
      eff_base  = up & BASE_MASK;
      real_base = lo & BASE_MASK;
      priv_ok   = user ? up[0] : up[1];
      hit       = priv_ok && (eff_base == (ea & cmp_mask));
      pa        = real_base + (ea - eff_base);
   end
endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
   import blk_xlate_pkg::*;
#(
   parameter int W       = 32,
   parameter int N_ENT   = 8,
   parameter int LEN_W   = 11,
   parameter int LEN_LSB = 2,
   parameter int SHIFT   = 17,
   parameter int SPR_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [W-1:0]     req_ea,
   input  logic             req_side,
   input  logic             req_user,
   input  logic             xlate_en,
   output logic             rsp_valid,
   output logic [W-1:0]     rsp_pa,
   output logic             rsp_hit,
   input  logic             reg_we,
   input  logic [SPR_W-1:0] reg_addr,
   input  logic [W-1:0]     reg_wdata,
   output logic [W-1:0]     reg_rdata,
   output logic             cache_flush
);
   localparam int N_SIDE = 2;

   if (N_ENT != (1 << IDX_W)) begin : g_bad_ent
      initial $fatal(1, "N_ENT must match the register-number decode");
   end
   if (LEN_LSB + LEN_W > SHIFT || SHIFT + LEN_W > W) begin : g_bad_len
      initial $fatal(1, "length field overlaps the block base");
   end
   if (SPR_W != 10) begin : g_bad_spr
      initial $fatal(1, "register-number width must be 10");
   end

   regsel_t      sel;
   logic [W-1:0] up_all [N_SIDE][N_ENT];
   logic [W-1:0] lo_all [N_SIDE][N_ENT];
   logic         hit_v  [N_SIDE][N_ENT];
   logic [W-1:0] pa_v   [N_SIDE][N_ENT];

   blk_xlate_regsel #(.SPR_W(SPR_W)) u_sel (
      .addr (reg_addr),
      .sel  (sel)
   );

   for (genvar s = 0; s < N_SIDE; s++) begin : g_side
      logic bank_we;
      assign bank_we = reg_we && sel.mapped && (sel.side == side_e'(s));

      blk_xlate_bank #(.N_ENT(N_ENT), .W(W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (bank_we),
         .widx   (sel.idx),
         .wlower (sel.lower),
         .wdata  (reg_wdata),
         .up_q   (up_all[s]),
         .lo_q   (lo_all[s])
      );

      for (genvar e = 0; e < N_ENT; e++) begin : g_ent
         blk_xlate_entry #(
            .W(W), .LEN_W(LEN_W), .LEN_LSB(LEN_LSB), .SHIFT(SHIFT)
         ) u_ent (
            .up   (up_all[s][e]),
            .lo   (lo_all[s][e]),
            .ea   (req_ea),
            .user (req_user),
            .hit  (hit_v[s][e]),
            .pa   (pa_v[s][e])
         );
      end
   end

   // Lowest index wins: scan downward so the last assignment is the lowest.
   logic         any_hit;
   logic [W-1:0] sel_pa;
   always_comb begin
      any_hit = 1'b0;
      sel_pa  = '0;
      for (int e = N_ENT - 1; e >= 0; e--) begin
         if (hit_v[req_side][e]) begin
            any_hit = 1'b1;
            sel_pa  = pa_v[req_side][e];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel.mapped) begin
         reg_rdata = sel.lower ? lo_all[sel.side][sel.idx]
                               : up_all[sel.side][sel.idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pa      <= '0;
         rsp_hit     <= 1'b0;
         cache_flush <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         cache_flush <= reg_we && sel.mapped;
         if (req_valid) begin
            if (!xlate_en) begin
               rsp_pa  <= req_ea;
               rsp_hit <= 1'b1;
            end else begin
               rsp_pa  <= sel_pa;
               rsp_hit <= any_hit;
            end
         end
      end
   end
endmodule

// File: rtl/blk_xlate_chk.sv
module blk_xlate_chk #(
   parameter int W     = 32,
   parameter int SPR_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [W-1:0]     req_ea,
   input logic             xlate_en,
   input logic             rsp_valid,
   input logic [W-1:0]     rsp_pa,
   input logic             rsp_hit,
   input logic             reg_we,
   input logic [SPR_W-1:0] reg_addr,
   input logic [W-1:0]     reg_rdata,
   input logic             cache_flush
);
   logic num_ok;
   assign num_ok = (reg_addr[SPR_W-1:6] == 4'b1000);

   AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xlate_en) |=> (rsp_hit && rsp_pa == $past(req_ea))); // R1

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R11

   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R11

   AST_FLUSH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && num_ok) |=> cache_flush); // R9

   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cache_flush |-> $past(reg_we && num_ok)); // R9

   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !num_ok |-> (reg_rdata == '0)); // R8
endmodule

bind blk_xlate blk_xlate_chk #(.W(W), .SPR_W(SPR_W)) u_chk (.*);

// File: tb/sim_blk_xlate.sv
module sim_blk_xlate;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic        req_side = 1'b0;
   logic        req_user = 1'b0;
   logic        xlate_en = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic        rsp_hit;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cache_flush;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] m_up [2][8];
   logic [31:0] m_lo [2][8];

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_xlate u0 (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] num(bit side, int idx, bit lower, bit b4);
      return 10'h200 | (idx >= 4 ? 10'h020 : 10'h0) | (10'(b4) << 4)
             | (10'(side) << 3) | (10'(idx & 3) << 1) | 10'(lower);
   endfunction

   function automatic logic [32:0] ref_xlate(bit side, bit user, bit en,
                                             logic [31:0] ea);
      if (!en) return {1'b1, ea};
      for (int e = 0; e < 8; e++) begin
         logic [31:0] up, mask, base;
         bit ok;
         up   = m_up[side][e];
         ok   = user ? up[0] : up[1];
         mask = ~{21'b0, up[12:2]} << 17;
         base = up & 32'hFFFE_0000;
         if (ok && base == (ea & mask))
            return {1'b1, (m_lo[side][e] & 32'hFFFE_0000) + (ea - base)};
      end
      return 33'h0;
   endfunction

   task automatic do_wr(logic [9:0] a, logic [31:0] d, bit mapped,
                        bit side, int idx, bit lower, string req);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      chk(req, 32'(cache_flush), 32'(mapped));
      if (mapped) begin
         if (lower) m_lo[side][idx] = d;
         else       m_up[side][idx] = d;
      end
   endtask

   task automatic wr_ent(bit side, int idx, logic [31:0] up, logic [31:0] lo);
      do_wr(num(side, idx, 1'b0, 1'b1), up, 1'b1, side, idx, 1'b0, "R9");
      do_wr(num(side, idx, 1'b1, 1'b0), lo, 1'b1, side, idx, 1'b1, "R9");
   endtask

   task automatic do_req(bit side, bit user, bit en, logic [31:0] ea, string req);
      logic [32:0] exp;
      exp = ref_xlate(side, user, en, ea);
      @(negedge clk);
      req_valid = 1'b1; req_side = side; req_user = user;
      xlate_en = en; req_ea = ea;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R11", 32'(rsp_valid), 32'd1);
      chk(req, 32'(rsp_hit), 32'(exp[32]));
      chk(req, rsp_pa, exp[31:0]);
   endtask

   task automatic do_rd(logic [9:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
   endtask

   bit done = 1'b0;

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h1A2B);
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 8; e++) begin m_up[s][e] = '0; m_lo[s][e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      chk("R10", 32'(cache_flush), 32'd0);
      do_rd(num(1, 5, 1, 1), 32'h0, "R10");
      do_rd(num(0, 0, 0, 1), 32'h0, "R10");
      do_req(1, 0, 1, 32'h0000_0000, "R10");

      // R1: pass-through
      do_req(0, 1, 0, 32'hDEAD_BEEF, "R1");

      // R3/R4: 256 KB block (len=1) at 0x1000_0000 -> 0x8000_0000, supervisor
      wr_ent(1, 0, 32'h1000_0006, 32'h8000_0000);
      do_req(1, 0, 1, 32'h1003_1234, "R4");
      do_req(1, 0, 1, 32'h1004_0000, "R3");
      // R2: user enable clear -> miss; then set user only
      do_req(1, 1, 1, 32'h1001_0000, "R2");
      wr_ent(1, 0, 32'h1000_0005, 32'h8000_0000);
      do_req(1, 1, 1, 32'h1001_0000, "R2");
      do_req(1, 0, 1, 32'h1001_0000, "R2");
      // R6: instruction side does not see data entry
      do_req(0, 1, 1, 32'h1001_0000, "R6");
      // R5/R7: overlapping entries 2 and 5 (index 5 via bit 5)
      wr_ent(0, 5, 32'h2000_0003, 32'h4000_0000);
      do_req(0, 0, 1, 32'h2001_0010, "R7");
      wr_ent(0, 2, 32'h2000_0003, 32'h6000_0000);
      do_req(0, 0, 1, 32'h2001_0010, "R5");
      do_rd(num(0, 5, 1, 0), 32'h4000_0000, "R7");
      do_rd(num(0, 5, 1, 1), 32'h4000_0000, "R7");
      do_rd(num(0, 2, 0, 0), 32'h2000_0003, "R8");
      // R8/R9: unmapped numbers
      do_wr(10'h260, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, "R9");
      do_wr(10'h1F1, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, "R9");
      do_rd(10'h260, 32'h0, "R8");
      do_rd(num(0, 2, 0, 0), 32'h2000_0003, "R8");
      do_req(0, 0, 1, 32'h2001_0010, "R8");
      // R9: pulse lasts one cycle
      do_wr(num(1, 7, 1, 0), 32'h1234_0000, 1'b1, 1, 7, 1, "R9");
      @(negedge clk);
      chk("R9", 32'(cache_flush), 32'd0);

      // Random mix
      for (int it = 0; it < 3000; it++) begin
         int kind;
         kind = $urandom_range(0, 9);
         if (kind < 2) begin
            bit side; int idx; int k; logic [31:0] len, mask, up;
            side = 1'($urandom); idx = $urandom_range(0, 7);
            k = $urandom_range(0, 11);
            len = (32'h1 << k) - 1;
            mask = ~len << 17;
            up = ($urandom & mask & 32'hFFFE_0000) | (len << 2)
                 | 32'($urandom_range(0, 3));
            wr_ent(side, idx, up, $urandom);
         end else if (kind == 2) begin
            bit side; int idx; bit lo;
            side = 1'($urandom); idx = $urandom_range(0, 7); lo = 1'($urandom);
            do_rd(num(side, idx, lo, 1'($urandom)),
                  lo ? m_lo[side][idx] : m_up[side][idx], "R8");
         end else begin
            bit side; int idx; logic [31:0] up, mask, ea;
            side = 1'($urandom); idx = $urandom_range(0, 7);
            up = m_up[side][idx];
            mask = ~{21'b0, up[12:2]} << 17;
            ea = (kind == 9) ? $urandom : ((up & mask) | ($urandom & ~mask));
            do_req(side, 1'($urandom), $urandom_range(0, 7) != 0, ea, "R5");
         end
      end
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule